// File: doc/BRIEF.md
# Package idle-state resolver

This block works out the idle level of each core from the requests of its threads. It then works out one idle level for the whole package from those core levels. Each thread presents a requested idle level and a wake strobe. A core can only be as deep as its least-idle thread. The package can only be as deep as its least-idle core.

The platform gives two permission inputs, one for each deep package level. The package never goes deeper than the platform allows. When the package sits in a deep level and no memory traffic is waiting, the block asserts a DRAM self-refresh enable.

All outputs are registered. The inputs are plain level signals, sampled every clock, so there is no handshake and no back-pressure. Power gating itself is left to the logic that consumes these outputs.

Top module: `idle_state_resolver`

## Requirements
- R1: Idle levels use a 2-bit code in which a larger value means deeper sleep: 0 = active (C0), 1 = halt (C1/C1E), 2 = sleep (C3), 3 = deep sleep (C6). Thread t drives bits [2t+1:2t] of `thr_req`. Core c owns threads c*THR_PER_CORE up to c*THR_PER_CORE+THR_PER_CORE-1 and drives bits [2c+1:2c] of `core_state`.
- R2: One clock edge after the inputs are sampled, each core's state equals the shallowest level requested among its threads. A single thread asking for a deeper level does not move its core while a sibling thread stays shallower.
- R3: `pkg_req` equals the shallowest of the core states and updates on the same edge as `core_state`.
- R4: The package state is 0 whenever `pkg_req` is 0 or 1, and whenever no permission covers the requested depth. The package state never takes the value 1.
- R5: The package goes to level 2 when `pkg_req` is 2 or deeper, `grant_shallow` is high, and the conditions for level 3 are not met.
- R6: The package goes to level 3 only when `pkg_req` is 3 and `grant_deep` is high. `grant_deep` does not also permit level 2.
- R7: If a permission is withdrawn, or `pkg_req` becomes shallower, the package moves to the deepest level still permitted on the very next edge.
- R8: The package moves deeper only when the newly resolved request equals the `pkg_req` already registered. A stable new request therefore deepens the package one edge after `pkg_req` reaches it.
- R9: `dram_sr_en` is high exactly when the package state being registered is 2 or 3 and `mem_pending` is low. It changes on the same edge as `pkg_state`.
- R10: A wake strobe on any thread forces that thread's level to 0. On the next edge its core, `pkg_req` and `pkg_state` become 0 and `dram_sr_en` drops.
- R11: While `rst_n` is low, every core, `pkg_req` and `pkg_state` are 0 and `dram_sr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_req | input | 2*N_CORES*THR_PER_CORE | Requested idle level per thread |
| thr_wake | input | N_CORES*THR_PER_CORE | Wake strobe per thread |
| grant_shallow | input | 1 | Platform permits package level 2 |
| grant_deep | input | 1 | Platform permits package level 3 |
| mem_pending | input | 1 | Memory requests are waiting |
| core_state | output | 2*N_CORES | Resolved idle level per core |
| pkg_req | output | 2 | Shallowest core level, offered to the platform |
| pkg_state | output | 2 | Resolved package idle level |
| dram_sr_en | output | 1 | DRAM self-refresh enable |

## Verification
Each core state is registered straight from the thread inputs, so a wrong core merge shows up on `core_state` and `pkg_req` one edge after the stimulus. A fault in the permission cap or the stability rule shows up on `pkg_state` and `dram_sr_en`. A deepening that happens too early shows on the first edge after the request changes. A missing return to a shallower level shows on the first edge after a permission falls or a wake arrives. The bench therefore checks both the settled values and the exact edge on which the package deepens, falls back, and wakes.

// File: rtl/idle_res_pkg.sv
package idle_res_pkg;
  typedef logic [1:0] idle_t;
  // R1: ordered code, larger value means deeper sleep
  localparam idle_t IDLE_RUN   = 2'd0;
  localparam idle_t IDLE_HALT  = 2'd1;
  localparam idle_t IDLE_SLEEP = 2'd2;
  localparam idle_t IDLE_DEEP  = 2'd3;
  localparam int    IDLE_W     = 2;
endpackage

// File: rtl/idle_core_merge.sv
module idle_core_merge
  import idle_res_pkg::*;
#(
  parameter int THR_PER_CORE = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [THR_PER_CORE*IDLE_W-1:0] thr_req,
  input  logic [THR_PER_CORE-1:0]        thr_wake,
  output idle_t                          core_next,
  output idle_t                          core_q
);

  // Shallowest effective thread level; a wake strobe counts as active (R2, R10)
  always_comb begin
    core_next = IDLE_DEEP;
    for (int t = 0; t < THR_PER_CORE; t++) begin
      if (thr_wake[t]) begin
        core_next = IDLE_RUN;
      end else if (thr_req[t*IDLE_W +: IDLE_W] < core_next) begin
        core_next = thr_req[t*IDLE_W +: IDLE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) core_q <= IDLE_RUN;
    else        core_q <= core_next;
  end

  for (genvar g = 0; g < THR_PER_CORE; g++) begin : g_chk
    // R2: the core is never deeper than any of its threads asked for
    a_r2_not_deeper_than_thread: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> core_q <= $past(thr_req[g*IDLE_W +: IDLE_W]));
    // R10: a wake strobe returns the core to active on the next edge
    a_r10_wake_core: assert property (@(posedge clk) disable iff (!rst_n)
      thr_wake[g] |=> core_q == IDLE_RUN);
  end

endmodule

// File: rtl/idle_pkg_arbiter.sv
module idle_pkg_arbiter
  import idle_res_pkg::*;
#(
  parameter int N_CORES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_CORES*IDLE_W-1:0] core_next,
  input  logic                      grant_shallow,
  input  logic                      grant_deep,
  input  logic                      mem_pending,
  output idle_t                     pkg_req_q,
  output idle_t                     pkg_state_q,
  output logic                      sr_q
);

  idle_t req_next;
  idle_t target;
  idle_t pkg_next;
  logic  sr_next;

  always_comb begin
    // R3: shallowest core
    req_next = IDLE_DEEP;
    for (int c = 0; c < N_CORES; c++) begin
      if (core_next[c*IDLE_W +: IDLE_W] < req_next) begin
        req_next = core_next[c*IDLE_W +: IDLE_W];
      end
    end
    // R4, R5, R6: cap by platform permission, no package level 1
    if (req_next == IDLE_DEEP && grant_deep) begin
      target = IDLE_DEEP;
    end else if (req_next >= IDLE_SLEEP && grant_shallow) begin
      target = IDLE_SLEEP;
    end else begin
      target = IDLE_RUN;
    end
    // R7, R8: fall back at once, deepen only on a stable request
    if (target > pkg_state_q && req_next != pkg_req_q) begin
      pkg_next = pkg_state_q;
    end else begin
      pkg_next = target;
    end
    // R9
    sr_next = (pkg_next != IDLE_RUN) && !mem_pending;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkg_req_q   <= IDLE_RUN;
      pkg_state_q <= IDLE_RUN;
      sr_q        <= 1'b0;
    end else begin
      pkg_req_q   <= req_next;
      pkg_state_q <= pkg_next;
      sr_q        <= sr_next;
    end
  end

  a_r4_state_within_request: assert property (@(posedge clk) disable iff (!rst_n)
    pkg_state_q <= pkg_req_q);
  a_r4_never_halt: assert property (@(posedge clk) disable iff (!rst_n)
    pkg_state_q != IDLE_HALT);
  a_r6_deep_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_deep |=> pkg_state_q != IDLE_DEEP);
  a_r8_deepen_on_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (pkg_state_q > $past(pkg_state_q)) |-> (pkg_req_q == $past(pkg_req_q)));
  a_r9_sr_only_deep: assert property (@(posedge clk) disable iff (!rst_n)
    sr_q |-> pkg_state_q != IDLE_RUN);
  a_r9_sr_off_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_pending |=> !sr_q);

endmodule

// File: rtl/idle_state_resolver.sv
module idle_state_resolver
  import idle_res_pkg::*;
#(
  parameter int N_CORES      = 4,
  parameter int THR_PER_CORE = 2
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [N_CORES*THR_PER_CORE*IDLE_W-1:0]  thr_req,
  input  logic [N_CORES*THR_PER_CORE-1:0]         thr_wake,
  input  logic                                    grant_shallow,
  input  logic                                    grant_deep,
  input  logic                                    mem_pending,
  output logic [N_CORES*IDLE_W-1:0]               core_state,
  output logic [1:0]                              pkg_req,
  output logic [1:0]                              pkg_state,
  output logic                                    dram_sr_en
);

  localparam int CORE_BITS = THR_PER_CORE * IDLE_W;

  logic [N_CORES*IDLE_W-1:0] core_next;

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    idle_core_merge #(.THR_PER_CORE(THR_PER_CORE)) u_merge (
      .clk       (clk),
      .rst_n     (rst_n),
      .thr_req   (thr_req[c*CORE_BITS +: CORE_BITS]),
      .thr_wake  (thr_wake[c*THR_PER_CORE +: THR_PER_CORE]),
      .core_next (core_next[c*IDLE_W +: IDLE_W]),
      .core_q    (core_state[c*IDLE_W +: IDLE_W])
    );
  end

  idle_pkg_arbiter #(.N_CORES(N_CORES)) u_arb (
    .clk           (clk),
    .rst_n         (rst_n),
    .core_next     (core_next),
    .grant_shallow (grant_shallow),
    .grant_deep    (grant_deep),
    .mem_pending   (mem_pending),
    .pkg_req_q     (pkg_req),
    .pkg_state_q   (pkg_state),
    .sr_q          (dram_sr_en)
  );

endmodule

// File: tb/idle_state_resolver_tb_top.sv
`timescale 1ns/1ps
module idle_state_resolver_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] thr_req = '0;
  logic [7:0]  thr_wake = '0;
  logic        grant_shallow = 1'b0;
  logic        grant_deep = 1'b0;
  logic        mem_pending = 1'b0;
  logic [7:0]  core_state;
  logic [1:0]  pkg_req;
  logic [1:0]  pkg_state;
  logic        dram_sr_en;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  idle_state_resolver #(.N_CORES(4), .THR_PER_CORE(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .thr_req(thr_req), .thr_wake(thr_wake),
    .grant_shallow(grant_shallow), .grant_deep(grant_deep),
    .mem_pending(mem_pending), .core_state(core_state), .pkg_req(pkg_req),
    .pkg_state(pkg_state), .dram_sr_en(dram_sr_en)
  );

  // {thr_req, grant_shallow, grant_deep, mem_pending, core, pkg_req, pkg_state, sr}
  localparam int NV = 10;
  localparam logic [31:0] VEC [NV] = '{
    {16'h0000, 1'b1, 1'b1, 1'b0, 8'h00, 2'd0, 2'd0, 1'b0}, // R4 all active
    {16'hFFFF, 1'b1, 1'b1, 1'b0, 8'hFF, 2'd3, 2'd3, 1'b1}, // R6 all deep, granted
    {16'hFFFF, 1'b1, 1'b0, 1'b1, 8'hFF, 2'd3, 2'd2, 1'b0}, // R5 deep capped, memory busy
    {16'hAAAA, 1'b1, 1'b1, 1'b0, 8'hAA, 2'd2, 2'd2, 1'b1}, // R5 all sleep
    {16'hFFFB, 1'b1, 1'b1, 1'b0, 8'hFE, 2'd2, 2'd2, 1'b1}, // R2 mixed threads in core0
    {16'hF7FF, 1'b1, 1'b1, 1'b0, 8'hDF, 2'd1, 2'd0, 1'b0}, // R4 one core halted
    {16'hFFFF, 1'b0, 1'b0, 1'b0, 8'hFF, 2'd3, 2'd0, 1'b0}, // R4 no permission
    {16'hAAAA, 1'b0, 1'b1, 1'b0, 8'hAA, 2'd2, 2'd0, 1'b0}, // R6 deep grant alone does not permit sleep
    {16'hFF3F, 1'b1, 1'b1, 1'b0, 8'hF3, 2'd0, 2'd0, 1'b0}, // R2 one active thread holds core1
    {16'hFFFF, 1'b1, 1'b1, 1'b1, 8'hFF, 2'd3, 2'd3, 1'b0}  // R9 deep but memory pending
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic all_out(input string tag, input logic [7:0] c, input logic [1:0] r,
                         input logic [1:0] p, input logic s);
    chk({tag, " R2 core_state"}, core_state, c);
    chk({tag, " R3 pkg_req"}, {6'd0, pkg_req}, {6'd0, r});
    chk({tag, " R5 pkg_state"}, {6'd0, pkg_state}, {6'd0, p});
    chk({tag, " R9 dram_sr_en"}, {7'd0, dram_sr_en}, {7'd0, s});
  endtask

  initial begin
    // R11 reset state
    edges(2);
    all_out("R11 reset", 8'h00, 2'd0, 2'd0, 1'b0);
    rst_n = 1'b1;
    edges(1);

    // R1 encoding drives every table row
    for (int i = 0; i < NV; i++) begin
      {thr_req, grant_shallow, grant_deep, mem_pending} = VEC[i][31:13];
      edges(3);
      all_out($sformatf("vec%0d", i), VEC[i][12:5], VEC[i][4:3], VEC[i][2:1], VEC[i][0]);
    end

    // R8: deepening waits one edge after pkg_req settles
    thr_req = 16'h0000; grant_shallow = 1'b1; grant_deep = 1'b1; mem_pending = 1'b0;
    edges(3);
    thr_req = 16'hFFFF;
    edges(1);
    all_out("R8 first edge", 8'hFF, 2'd3, 2'd0, 1'b0);
    edges(1);
    all_out("R8 second edge", 8'hFF, 2'd3, 2'd3, 1'b1);

    // R7: withdrawn permissions take effect on the next edge
    grant_deep = 1'b0;
    edges(1);
    all_out("R7 deep withdrawn", 8'hFF, 2'd3, 2'd2, 1'b1);
    grant_shallow = 1'b0;
    edges(1);
    all_out("R7 all withdrawn", 8'hFF, 2'd3, 2'd0, 1'b0);

    // R9: memory traffic drops self-refresh on the same edge, package stays
    grant_shallow = 1'b1; grant_deep = 1'b1;
    edges(3);
    mem_pending = 1'b1;
    edges(1);
    all_out("R9 memory pending", 8'hFF, 2'd3, 2'd3, 1'b0);
    mem_pending = 1'b0;
    edges(1);
    all_out("R9 memory idle", 8'hFF, 2'd3, 2'd3, 1'b1);

    // R10: one-cycle wake on thread 5 (core 2)
    thr_wake = 8'h20;
    edges(1);
    thr_wake = 8'h00;
    all_out("R10 wake", 8'hCF, 2'd0, 2'd0, 1'b0);
    edges(1);
    all_out("R10 after wake", 8'hFF, 2'd3, 2'd0, 1'b0);
    edges(1);
    all_out("R10 re-enter", 8'hFF, 2'd3, 2'd3, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule